// File: doc/BRIEF.md
# UART Receive Status Flag Register

This block holds the receive-side status of a serial receiver. Three sticky error flags (noise, framing error and parity error) are set by one-cycle event pulses from the receiver core. They stay set until software runs a two-step clear: it reads the error status word while a flag is set, and then it reads the receive data word. A second status word reports two live conditions that the receiver core drives: break detected and reception in progress. An enable word gates each error flag onto its own interrupt request line.

Each error flag has its own clear-arm state machine with two states. In `ARM_IDLE` nothing is pending. In `ARM_WAIT` the flag was seen set by a status read and will clear on the next data read. The machine has three transitions. *Arm* moves from `ARM_IDLE` to `ARM_WAIT` on a read of the error status word while the flag is 1. *Fire* moves from `ARM_WAIT` to `ARM_IDLE` on a read of the data word, and clears the flag unless a new set event arrives in the same cycle. *Cancel* moves from `ARM_WAIT` to `ARM_IDLE` on any write to the error status word, and leaves the flag as it is.

The bus is a simple single-cycle register port. A read returns its data on `bus_rdata` one clock after the access, and `bus_rdata` holds that value until the next read.

Top module: `uart_rx_status`

## Requirements
- R1: Reset clears all three error flags, the enable word and `bus_rdata` to 0, and holds every interrupt output low.
- R2: A one-cycle pulse on `ev_noise`, `ev_frame` or `ev_parity` sets the matching flag, and the flag is visible from the next cycle. In the error status word (address 0), noise is bit 2, framing is bit 1 and parity is bit 0. Bits above bit 2 read 0, and a flag reads 1 when the condition has been detected.
- R3: A read of address 0 while a flag is 1, followed later by a read of the data word (address 2), clears that flag.
- R4: A data read that is not preceded by an arming status read leaves every flag unchanged. A status read arms only the flags that were 1 at that read, so a flag set after the status read survives the following data read.
- R5: If a set event arrives in the same cycle as the data read that would clear the same flag, the flag stays 1.
- R6: A write to address 0 does not change any flag. It also cancels every pending arm, so the next data read clears nothing.
- R7: The enable word at address 2'd3 is read/write. Bit 2 enables noise, bit 1 enables framing and bit 0 enables parity, and the upper bits read 0. Each interrupt output is high exactly while its flag and its enable bit are both 1.
- R8: The second status word (address 1) returns `rx_brk` at bit 1 and `rx_busy` at bit 0, with all higher bits 0.
- R9: A read of address 2 returns `rx_byte`. Every read result appears on `bus_rdata` one cycle after the access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_byte | input | DATA_W | Received byte from receiver core |
| ev_noise | input | 1 | Noise event pulse |
| ev_frame | input | 1 | Framing-error event pulse |
| ev_parity | input | 1 | Parity-error event pulse |
| rx_brk | input | 1 | Break detected (level) |
| rx_busy | input | 1 | Reception in progress (level) |
| irq_noise | output | 1 | Noise interrupt request |
| irq_frame | output | 1 | Framing-error interrupt request |
| irq_parity | output | 1 | Parity-error interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data word, a 2-bit address, and the four registers at addresses 0 to 3. With these values every address decodes to a register, so each access kind is reached. The byte width leaves five unimplemented bits above the flags and six above the second status word, and the bench checks that those bits read as zero. Writing all ones to the enable word shows that only three bits are stored.

// File: rtl/uart_rxstat_pkg.sv
package uart_rxstat_pkg;

    // Number of sticky error flags and their positions in the error word.
    localparam int ERR_N      = 3;
    localparam int ERR_NOISE  = 2;
    localparam int ERR_FRAME  = 1;
    localparam int ERR_PARITY = 0;

    // Positions in the second status word.
    localparam int STB_BRK  = 1;
    localparam int STB_BUSY = 0;
    localparam int STB_N    = 2;

    // Decoded bus access kinds.
    typedef enum logic [2:0] {
        ACC_NONE      = 3'd0,
        ACC_RD_STAT_A = 3'd1,
        ACC_RD_STAT_B = 3'd2,
        ACC_RD_DATA   = 3'd3,
        ACC_RD_IRQEN  = 3'd4,
        ACC_WR_STAT_A = 3'd5,
        ACC_WR_IRQEN  = 3'd6,
        ACC_WR_OTHER  = 3'd7
    } acc_e;

    // Per-flag clear-arm states.
    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_WAIT = 1'b1
    } arm_state_e;

endpackage

// File: rtl/rxstat_bus_decode.sv
module rxstat_bus_decode
    import uart_rxstat_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int STAT_A_ADDR = 0,
    parameter int STAT_B_ADDR = 1,
    parameter int DATA_ADDR   = 2,
    parameter int IRQEN_ADDR  = 3
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_e              acc
);

    localparam logic [ADDR_W-1:0] A_STAT_A = ADDR_W'(STAT_A_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT_B = ADDR_W'(STAT_B_ADDR);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(IRQEN_ADDR);

    always_comb begin
        acc = ACC_NONE;
        if (bus_en) begin
            if (bus_we) begin
                if (bus_addr == A_STAT_A) begin
                    acc = ACC_WR_STAT_A;
                end else if (bus_addr == A_IRQEN) begin
                    acc = ACC_WR_IRQEN;
                end else begin
                    acc = ACC_WR_OTHER;
                end
            end else begin
                if (bus_addr == A_STAT_A) begin
                    acc = ACC_RD_STAT_A;
                end else if (bus_addr == A_STAT_B) begin
                    acc = ACC_RD_STAT_B;
                end else if (bus_addr == A_DATA) begin
                    acc = ACC_RD_DATA;
                end else if (bus_addr == A_IRQEN) begin
                    acc = ACC_RD_IRQEN;
                end else begin
                    acc = ACC_NONE;
                end
            end
        end
    end

endmodule

// File: rtl/rxstat_flag_cell.sv
module rxstat_flag_cell
    import uart_rxstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic stat_wr_i,
    input  logic data_rd_i,
    output logic flag_o,
    output logic armed_o
);

    arm_state_e arm_q;
    arm_state_e arm_nx;
    logic       flag_q;
    logic       fire;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= ARM_IDLE;
        end else begin
            arm_q <= arm_nx;
        end
    end

    // Next state: arm, fire and cancel transitions.
    always_comb begin
        arm_nx = arm_q;
        unique case (arm_q)
            ARM_IDLE: begin
                if (stat_rd_i && flag_q) begin
                    arm_nx = ARM_WAIT;
                end
            end
            ARM_WAIT: begin
                if (stat_wr_i || data_rd_i) begin
                    arm_nx = ARM_IDLE;
                end
            end
        endcase
    end

    assign fire = (arm_q == ARM_WAIT) && data_rd_i;

    // Output process: the sticky flag, where a set event outranks a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (fire) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o  = flag_q;
    assign armed_o = (arm_q == ARM_WAIT);

endmodule

// File: rtl/rxstat_enable_reg.sv
module rxstat_enable_reg #(
    parameter int EN_N = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [EN_N-1:0] wdata_i,
    output logic [EN_N-1:0] en_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (wr_i) begin
            en_o <= wdata_i;
        end
    end

endmodule

// File: rtl/rxstat_rdata.sv
module rxstat_rdata
    import uart_rxstat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic [ERR_N-1:0]  flags_i,
    input  logic [STB_N-1:0]  statb_i,
    input  logic [ERR_N-1:0]  en_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int PAD_ERR = DATA_W - ERR_N;
    localparam int PAD_STB = DATA_W - STB_N;

    logic [DATA_W-1:0] rdata_nx;
    logic              take;

    always_comb begin
        rdata_nx = rdata_o;
        take     = 1'b1;
        unique case (acc)
            ACC_RD_STAT_A: rdata_nx = {{PAD_ERR{1'b0}}, flags_i};
            ACC_RD_STAT_B: rdata_nx = {{PAD_STB{1'b0}}, statb_i};
            ACC_RD_DATA:   rdata_nx = rx_byte_i;
            ACC_RD_IRQEN:  rdata_nx = {{PAD_ERR{1'b0}}, en_i};
            ACC_NONE, ACC_WR_STAT_A, ACC_WR_IRQEN, ACC_WR_OTHER: take = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (take) begin
            rdata_o <= rdata_nx;
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rxstat_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int STAT_A_ADDR = 0,
    parameter int STAT_B_ADDR = 1,
    parameter int DATA_ADDR   = 2,
    parameter int IRQEN_ADDR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              ev_noise,
    input  logic              ev_frame,
    input  logic              ev_parity,
    input  logic              rx_brk,
    input  logic              rx_busy,
    output logic              irq_noise,
    output logic              irq_frame,
    output logic              irq_parity
);

    acc_e             acc;
    logic [ERR_N-1:0] ev_vec;
    logic [ERR_N-1:0] flag_q;
    logic [ERR_N-1:0] armed;
    logic [ERR_N-1:0] en_q;
    logic [ERR_N-1:0] irq_vec;
    logic [STB_N-1:0] statb;
    logic             stat_rd;
    logic             stat_wr;
    logic             data_rd;
    logic             en_wr;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:ERR_N];

    rxstat_bus_decode #(
        .ADDR_W      (ADDR_W),
        .STAT_A_ADDR (STAT_A_ADDR),
        .STAT_B_ADDR (STAT_B_ADDR),
        .DATA_ADDR   (DATA_ADDR),
        .IRQEN_ADDR  (IRQEN_ADDR)
    ) u_dec (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .acc      (acc)
    );

    assign stat_rd = (acc == ACC_RD_STAT_A);
    assign stat_wr = (acc == ACC_WR_STAT_A);
    assign data_rd = (acc == ACC_RD_DATA);
    assign en_wr   = (acc == ACC_WR_IRQEN);

    always_comb begin
        ev_vec             = '0;
        ev_vec[ERR_NOISE]  = ev_noise;
        ev_vec[ERR_FRAME]  = ev_frame;
        ev_vec[ERR_PARITY] = ev_parity;
    end

    for (genvar k = 0; k < ERR_N; k++) begin : g_flag
        rxstat_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (ev_vec[k]),
            .stat_rd_i (stat_rd),
            .stat_wr_i (stat_wr),
            .data_rd_i (data_rd),
            .flag_o    (flag_q[k]),
            .armed_o   (armed[k])
        );
        assign irq_vec[k] = flag_q[k] & en_q[k];
    end

    rxstat_enable_reg #(
        .EN_N (ERR_N)
    ) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (bus_wdata[ERR_N-1:0]),
        .en_o    (en_q)
    );

    always_comb begin
        statb           = '0;
        statb[STB_BRK]  = rx_brk;
        statb[STB_BUSY] = rx_busy;
    end

    rxstat_rdata #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .flags_i   (flag_q),
        .statb_i   (statb),
        .en_i      (en_q),
        .rx_byte_i (rx_byte),
        .rdata_o   (bus_rdata)
    );

    assign irq_noise  = irq_vec[ERR_NOISE];
    assign irq_frame  = irq_vec[ERR_FRAME];
    assign irq_parity = irq_vec[ERR_PARITY];

endmodule

// File: rtl/rxstat_checker.sv
module rxstat_checker
    import uart_rxstat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ERR_N-1:0]  ev_i,
    input logic [ERR_N-1:0]  flag_i,
    input logic [ERR_N-1:0]  armed_i,
    input logic [ERR_N-1:0]  en_i,
    input logic [ERR_N-1:0]  irq_i,
    input logic              data_rd_i,
    input logic              stat_wr_i,
    input logic              statb_rd_i,
    input logic [DATA_W-1:0] rdata_i
);

    // R1: a cycle in reset leaves flags and enables at zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (flag_i == '0 && en_i == '0));

    // R2 and R5: every event pulse yields a set flag, even against a clearing read.
    p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((flag_i & $past(ev_i)) == $past(ev_i)));

    // R4: without a data read, no flag drops.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd_i |=> ((flag_i & $past(flag_i)) == $past(flag_i)));

    // R3: a data read drops only flags that were armed.
    p_drop_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_i |=> (($past(flag_i) & ~flag_i & ~$past(armed_i)) == '0));

    // R6: a write to the error word leaves nothing armed.
    p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_i |=> (armed_i == '0));

    // R7: an interrupt needs both its flag and its enable.
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_i & ~en_i) == '0) && ((irq_i & ~flag_i) == '0));

    // R8: the second status word has nothing above bit 1.
    p_statb_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        statb_rd_i |=> (rdata_i[DATA_W-1:STB_N] == '0));

endmodule

bind uart_rx_status rxstat_checker #(
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev_vec),
    .flag_i     (flag_q),
    .armed_i    (armed),
    .en_i       (en_q),
    .irq_i      (irq_vec),
    .data_rd_i  (data_rd),
    .stat_wr_i  (stat_wr),
    .statb_rd_i (acc == uart_rxstat_pkg::ACC_RD_STAT_B),
    .rdata_i    (bus_rdata)
);

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int NV     = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [DATA_W-1:0] rx_byte = 8'h5A;
    logic              ev_noise = 1'b0;
    logic              ev_frame = 1'b0;
    logic              ev_parity = 1'b0;
    logic              rx_brk = 1'b0;
    logic              rx_busy = 1'b0;
    logic              irq_noise;
    logic              irq_frame;
    logic              irq_parity;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    uart_rx_status u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rx_byte    (rx_byte),
        .ev_noise   (ev_noise),
        .ev_frame   (ev_frame),
        .ev_parity  (ev_parity),
        .rx_brk     (rx_brk),
        .rx_busy    (rx_busy),
        .irq_noise  (irq_noise),
        .irq_frame  (irq_frame),
        .irq_parity (irq_parity)
    );

    // Vector: en, we, addr[2], wdata[8], ev{noise,frame,parity}, chk, expected rdata[8], req[4]
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 8'h00, 4'd1}, // R1 error word after reset
        {1'b0, 1'b0, 2'd0, 8'h00, 3'b100, 1'b0, 8'h00, 4'd2}, // R2 noise pulse
        {1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 8'h04, 4'd2}, // R2 noise at bit 2, arms it
        {1'b1, 1'b0, 2'd2, 8'h00, 3'b000, 1'b1, 8'h5A, 4'd3}, // R3 data read fires
        {1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 8'h00, 4'd3}, // R3 noise cleared
        {1'b0, 1'b0, 2'd0, 8'h00, 3'b011, 1'b0, 8'h00, 4'd4}, // R4 frame+parity pulses
        {1'b1, 1'b0, 2'd2, 8'h00, 3'b000, 1'b1, 8'h5A, 4'd4}, // R4 unarmed data read
        {1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 8'h03, 4'd4}, // R4 both survive, now armed
        {1'b0, 1'b0, 2'd0, 8'h00, 3'b100, 1'b0, 8'h00, 4'd4}, // R4 noise after arming
        {1'b1, 1'b0, 2'd2, 8'h00, 3'b000, 1'b1, 8'h5A, 4'd4}, // R4 fire
        {1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 8'h04, 4'd4}, // R4 late noise survives
        {1'b1, 1'b1, 2'd0, 8'hFF, 3'b000, 1'b0, 8'h00, 4'd6}, // R6 write cancels arm
        {1'b1, 1'b0, 2'd2, 8'h00, 3'b000, 1'b1, 8'h5A, 4'd6}, // R6 data read after cancel
        {1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 8'h04, 4'd6}, // R6 noise kept
        {1'b1, 1'b0, 2'd2, 8'h00, 3'b100, 1'b1, 8'h5A, 4'd5}, // R5 set with clearing read
        {1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 8'h04, 4'd5}, // R5 set wins
        {1'b1, 1'b0, 2'd2, 8'h00, 3'b000, 1'b1, 8'h5A, 4'd3}, // R3 fire
        {1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 8'h00, 4'd3}, // R3 all clear
        {1'b1, 1'b1, 2'd0, 8'hFF, 3'b000, 1'b0, 8'h00, 4'd6}, // R6 write ones to error word
        {1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 8'h00, 4'd6}, // R6 no flag set by write
        {1'b1, 1'b1, 2'd3, 8'hFF, 3'b000, 1'b0, 8'h00, 4'd7}, // R7 enable all ones
        {1'b1, 1'b0, 2'd3, 8'h00, 3'b000, 1'b1, 8'h07, 4'd7}, // R7 only 3 bits kept
        {1'b1, 1'b1, 2'd3, 8'h05, 3'b000, 1'b0, 8'h00, 4'd7}, // R7 enable noise+parity
        {1'b1, 1'b0, 2'd3, 8'h00, 3'b000, 1'b1, 8'h05, 4'd7}  // R7 readback
    };

    task automatic check(input string tag, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle, then release at 1 ns after the edge.
    task automatic cyc(input logic en, input logic we, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] wd, input logic [2:0] ev);
        bus_en    = en;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = wd;
        {ev_noise, ev_frame, ev_parity} = ev;
        @(posedge clk);
        #1;
        bus_en = 1'b0;
        bus_we = 1'b0;
        {ev_noise, ev_frame, ev_parity} = 3'b000;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state at the ports
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 irqs", {5'd0, irq_noise, irq_frame, irq_parity}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            cyc(v[27], v[26], v[25:24], v[23:16], v[15:13]);
            if (v[12]) begin
                check($sformatf("R%0d vec%0d", v[3:0], i), bus_rdata, v[11:4]);
            end
        end

        // R7 interrupt gating with enable = 3'b101
        cyc(1'b0, 1'b0, 2'd0, 8'h00, 3'b111);
        check("R7 irq en101", {5'd0, irq_noise, irq_frame, irq_parity}, 8'h05);
        cyc(1'b1, 1'b1, 2'd3, 8'h02, 3'b000);
        check("R7 irq en010", {5'd0, irq_noise, irq_frame, irq_parity}, 8'h02);

        // R8 second status word
        rx_brk = 1'b1; rx_busy = 1'b0;
        cyc(1'b1, 1'b0, 2'd1, 8'h00, 3'b000);
        check("R8 brk", bus_rdata, 8'h02);
        rx_brk = 1'b0; rx_busy = 1'b1;
        cyc(1'b1, 1'b0, 2'd1, 8'h00, 3'b000);
        check("R8 busy", bus_rdata, 8'h01);
        rx_brk = 1'b1;
        cyc(1'b1, 1'b0, 2'd1, 8'h00, 3'b000);
        check("R8 both", bus_rdata, 8'h03);

        // R9 data word follows rx_byte and holds between reads
        rx_byte = 8'hA5;
        cyc(1'b1, 1'b0, 2'd2, 8'h00, 3'b000);
        check("R9 data", bus_rdata, 8'hA5);
        rx_byte = 8'h3C;
        cyc(1'b0, 1'b0, 2'd2, 8'h00, 3'b000);
        check("R9 hold", bus_rdata, 8'hA5);

        // R1 mid-run reset with flags and enables set
        cyc(1'b1, 1'b1, 2'd3, 8'h07, 3'b111);
        check("R1 pre irqs", {5'd0, irq_noise, irq_frame, irq_parity}, 8'h07);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 irqs in reset", {5'd0, irq_noise, irq_frame, irq_parity}, 8'h00);
        check("R1 rdata in reset", bus_rdata, 8'h00);
        rst_n = 1'b1;
        cyc(1'b1, 1'b0, 2'd0, 8'h00, 3'b000);
        check("R1 flags after reset", bus_rdata, 8'h00);
        cyc(1'b1, 1'b0, 2'd3, 8'h00, 3'b000);
        check("R1 enable after reset", bus_rdata, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule